// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus. Software programs a clock divider, a PHY address, a PHY register address and a 16-bit write value, then writes a command. The block derives the management clock from the system clock, shifts out a management frame with the most significant bit first, and releases the data line for a read so the PHY can answer. Read results land in a receive register.

A status word reports busy, link failure and invalid data. In scan mode the block keeps reading the PHY's basic status register (register 1 by default) one frame after another. It takes link failure from each result and holds the invalid flag high until the first result has arrived. The data line is split into an output value, an output enable and an input, so a pad-level tri-state buffer can be placed outside the block.

Top module: `mdio_master`

## Requirements
- R1: While a frame is in progress, the management clock period is E system clocks, where E is the mode divider field (bits 7:0) with bit 0 cleared, and any value below 2 gives 2. The clock is low whenever the block is idle.
- R2: A write command (command bit 2) sends 32 ones. It then sends bits 01, 01, the PHY address, the register address, 10 and the 16 data bits, all MSB first. Each bit is presented while the clock is low.
- R3: With mode bit 8 set, the 32 ones are left out and the frame is exactly 32 clock periods long. Otherwise it is 64.
- R4: A read command (command bit 1) sends opcode 10 and releases the line from the first turnaround bit (frame bit 14) to the end. It samples 16 data bits on rising clock edges. The result appears in the receive register (select 4, bits 15:0) when the frame ends.
- R5: Status bit 1 (busy) is high from the clock edge that takes the command until the frame completes, and it holds while the clock is high. The data output changes only when the clock falls.
- R6: A nonzero command written while busy is dropped. The command register keeps its value, no new frame starts, and the receive register is untouched. A zero write is always taken.
- R7: A scan command (command bit 0) reads register 1 of the programmed PHY again and again. Each result sets link fail (status bit 0) to the inverse of result bit 2. Invalid (status bit 2) is set when the scan starts and clears with the first result.
- R8: When the command is cleared during a scan, the frame in progress completes and no further frame starts.
- R9: Register selects are 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data and 5 status. The address register holds the PHY address in bits 4:0 and the register address in bits 12:8. Mode, command and address read back as written.
- R10: After reset the clock is low, the line is released, status reads 0, the command reads 0 and the mode reads the reset divider (20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Busy is due at the first clock edge after the command write, so the bench reads status on the falling system clock edge that follows. Frame bits are due at each rising management clock edge, and the bench captures the line there. The PHY responder drives read data only after a falling management clock edge, at least one system clock before the master samples. Receive data, link fail and invalid are due at the falling management clock edge that closes the frame. The bench checks them only after busy has dropped, or after the first rising edge of the next scan frame. Divider checks measure the time between the last two rising edges of each frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W      = 8;
  localparam int PHY_W      = 5;
  localparam int DATA_W     = 16;
  localparam int CMD_W      = 3;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int POS_W      = $clog2(PRE_BITS + FRAME_BITS);
  localparam int FPOS_W     = $clog2(FRAME_BITS);
  localparam int HALF_W     = DIV_W - 1;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_ADDR = 3'd2,
    SEL_TXD  = 3'd3,
    SEL_RXD  = 3'd4,
    SEL_STAT = 3'd5
  } reg_sel_e;

  // system clocks per management clock phase: even divider / 2, minimum 1
  function automatic logic [HALF_W-1:0] half_count(input logic [DIV_W-1:0] d);
    logic [HALF_W-1:0] h;
    h = d[DIV_W-1:1];
    return (h == '0) ? HALF_W'(1) : h;
  endfunction

  // frame without preamble, first transmitted bit at the MSB
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              rd,
    input logic [PHY_W-1:0]  phy,
    input logic [PHY_W-1:0]  rg,
    input logic [DATA_W-1:0] wd
  );
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, (rd ? DATA_W'(0) : wd)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt;
  logic              tick;

  assign half     = half_count(div);
  assign tick     = en && (cnt >= half - 1'b1);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc) || $fell(mdc)) |-> $past(tick)); // R1
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic              nopre,
  input  logic [PHY_W-1:0]  phy,
  input  logic [PHY_W-1:0]  rg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [FPOS_W-1:0] TA_POS   = FPOS_W'(FRAME_BITS - DATA_W - 2);
  localparam logic [FPOS_W-1:0] DATA_POS = FPOS_W'(FRAME_BITS - DATA_W);
  localparam logic [FPOS_W-1:0] LAST_POS = FPOS_W'(FRAME_BITS - 1);

  logic                  is_rd, nopre_q;
  logic [FRAME_BITS-1:0] frame;
  logic [POS_W-1:0]      pos, rel;
  logic [FPOS_W-1:0]     fpos;
  logic                  in_pre, last, released, sample_now;

  assign rel        = nopre_q ? pos : pos - POS_W'(PRE_BITS);
  assign fpos       = FPOS_W'(rel);
  assign in_pre     = !nopre_q && (pos < POS_W'(PRE_BITS));
  assign last       = !in_pre && (fpos == LAST_POS);
  assign released   = is_rd && !in_pre && (fpos >= TA_POS);
  assign sample_now = busy && rise_stb && is_rd && !in_pre && (fpos >= DATA_POS);
  assign done       = busy && fall_stb && last;
  assign mdio_o     = (!busy || in_pre) ? 1'b1 : frame[LAST_POS - fpos];
  assign mdio_oe    = busy && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      nopre_q <= 1'b0;
      frame   <= '0;
      pos     <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      is_rd   <= start_rd;
      nopre_q <= nopre;
      frame   <= build_frame(start_rd, phy, rg, wdata);
      pos     <= '0;
    end else if (done) begin
      busy    <= 1'b0;
    end else if (busy && fall_stb) begin
      pos     <= pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (sample_now) rdata <= {rdata[DATA_W-2:0], mdio_i};
  end

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !start) |=> busy); // R5
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> !mdio_oe); // R4
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 8'd20,
  parameter logic [PHY_W-1:0] SCAN_REG  = 5'd1,
  parameter int               LINK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              nopre_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [PHY_W-1:0]  phy_q, rg_q;
  logic [DATA_W-1:0] txd_q, rxd_q, seq_rdata;
  logic              link_fail, invalid, rd_fr, scan_fr;
  logic              busy, done, rise_stb, fall_stb;
  logic              cmd_wr, accept, launch, restart, start, start_rd, start_scan;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[15:13], reg_wdata[7:5]};

  assign cmd_wr     = reg_we && (reg_sel == SEL_CMD);
  assign accept     = cmd_wr && ((reg_wdata[CMD_W-1:0] == '0) || !busy);
  assign launch     = cmd_wr && !busy && (reg_wdata[CMD_W-1:0] != '0);
  assign restart    = done && cmd_q[0];
  assign start      = launch || restart;
  assign start_scan = launch ? reg_wdata[0] : 1'b1;
  assign start_rd   = launch ? (reg_wdata[0] | reg_wdata[1]) : 1'b1;

  mdio_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(busy), .div(div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .nopre(nopre_q), .phy(phy_q), .rg(start_scan ? SCAN_REG : rg_q),
    .wdata(txd_q), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .mdio_i(mdio_i), .busy(busy), .done(done), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rdata(seq_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DIV_RESET;
      nopre_q <= 1'b0;
      cmd_q   <= '0;
      phy_q   <= '0;
      rg_q    <= '0;
      txd_q   <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_MODE) begin
        div_q   <= reg_wdata[DIV_W-1:0];
        nopre_q <= reg_wdata[DIV_W];
      end
      if (reg_we && reg_sel == SEL_ADDR) begin
        phy_q <= reg_wdata[PHY_W-1:0];
        rg_q  <= reg_wdata[8 +: PHY_W];
      end
      if (reg_we && reg_sel == SEL_TXD) txd_q <= reg_wdata;
      if (accept) cmd_q <= reg_wdata[CMD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q     <= '0;
      link_fail <= 1'b0;
      invalid   <= 1'b0;
      rd_fr     <= 1'b0;
      scan_fr   <= 1'b0;
    end else begin
      if (done && rd_fr) rxd_q <= seq_rdata;
      if (done && scan_fr) begin
        link_fail <= ~seq_rdata[LINK_BIT];
        invalid   <= 1'b0;
      end
      if (launch && reg_wdata[0]) invalid <= 1'b1;
      if (start) begin
        rd_fr   <= start_rd;
        scan_fr <= start_scan;
      end
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_MODE: reg_rdata = DATA_W'({nopre_q, div_q});
      SEL_CMD:  reg_rdata = DATA_W'(cmd_q);
      SEL_ADDR: reg_rdata = DATA_W'({rg_q, 3'b000, phy_q});
      SEL_TXD:  reg_rdata = txd_q;
      SEL_RXD:  reg_rdata = rxd_q;
      SEL_STAT: reg_rdata = DATA_W'({invalid, busy, link_fail});
      default:  reg_rdata = '0;
    endcase
  end

  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R1
  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o)); // R5
  AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && reg_wdata[CMD_W-1:0] != '0) |=> $stable(cmd_q)); // R6
  AST_INVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(invalid) |-> $past(done)); // R7
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd5;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, phy_drv = 1'b1;
  wire         line = mdio_oe ? mdio_o : phy_drv;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  // line capture and PHY responder
  int          rise_cnt = 0, base = 0, flen = 64;
  logic [63:0] cap = '0;
  longint      prev_t = 0, last_t = 0;
  bit          resp_on = 0;
  logic [15:0] resp = '0;

  always @(posedge mdc) begin
    cap      <= {cap[62:0], line};
    rise_cnt <= rise_cnt + 1;
    prev_t   <= last_t;
    last_t   <= $time;
  end

  always @(negedge mdc) begin
    int k, q;
    k = (rise_cnt - base - 1) % flen;
    q = k - (flen - 32);
    if (!resp_on)                 phy_drv <= 1'b1;
    else if (q == 14)             phy_drv <= 1'b0;
    else if (q >= 15 && q <= 30)  phy_drv <= resp[30 - q];
    else                          phy_drv <= 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 3'd5;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
    reg_sel = 3'd5;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, v);
      if (!v[1]) break;
    end
  endtask

  function automatic logic [31:0] exp_frame(input bit r, input logic [4:0] p,
                                            input logic [4:0] g, input logic [15:0] d);
    logic [31:0] e;
    e = 32'd1;
    e = (e << 2) | (r ? 32'd2 : 32'd1);
    e = (e << 5) | 32'(p);
    e = (e << 5) | 32'(g);
    e = (e << 2) | (r ? 32'd0 : 32'd2);
    e = (e << 16) | (r ? 32'd0 : 32'(d));
    return e;
  endfunction

  function automatic int eff_div(input logic [7:0] d);
    return (d < 8'd2) ? 2 : int'(d) - int'(d % 2);
  endfunction

  // {rd, nopre, div[7:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [35:0] VEC [0:4] = '{
    {1'b0, 1'b0, 8'd2, 5'h03, 5'h00, 16'hA5C3},
    {1'b1, 1'b0, 8'd6, 5'h1F, 5'h11, 16'h3C5A},
    {1'b0, 1'b1, 8'd7, 5'h0A, 5'h1F, 16'h8001},
    {1'b1, 1'b1, 8'd1, 5'h15, 5'h02, 16'hFFFE},
    {1'b0, 1'b1, 8'd0, 5'h00, 5'h0E, 16'h7FFF}
  };

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(3'd5, v); check("R10 status", v, 0);
    rd(3'd1, v); check("R10 command", v, 0);
    rd(3'd0, v); check("R10 mode", v, 16'd20);
    check("R10 mdc/oe", {mdc, mdio_oe}, 0);

    foreach (VEC[i]) begin
      logic [35:0] e;
      bit r, np;
      logic [7:0] dv;
      logic [4:0] p, g;
      logic [15:0] d;
      e = VEC[i];
      {r, np, dv, p, g, d} = e;
      wr(3'd0, {7'd0, np, dv});
      wr(3'd2, {3'd0, g, 3'd0, p});
      wr(3'd3, d);
      rd(3'd2, v); check("R9 address readback", v, {3'd0, g, 3'd0, p});
      rd(3'd0, v); check("R9 mode readback", v, {7'd0, np, dv});
      base = rise_cnt; flen = np ? 32 : 64; resp_on = r; resp = d;
      n0 = rise_cnt;
      wr(3'd1, r ? 16'd2 : 16'd4);
      rd(3'd5, v); check("R5 busy after command", v[1], 1);
      wait_idle();
      check("R3 frame length", rise_cnt - n0, flen);
      if (!np) check("R2 preamble ones", cap[63:32], 32'hFFFF_FFFF);
      if (r) begin
        check("R4 read header", cap[31:18], exp_frame(1'b1, p, g, d) >> 18);
        rd(3'd4, v); check("R4 read data", v, d);
      end else begin
        check("R2 write frame", cap[31:0], exp_frame(1'b0, p, g, d));
      end
      check("R1 mdc period", last_t - prev_t, 8 * eff_div(dv));
      check("R1 mdc idle low", mdc, 0);
      wr(3'd1, 16'd0);
    end

    // R6 command ignored while busy
    resp_on = 0;
    wr(3'd0, 16'h0114);
    wr(3'd2, 16'h0201);
    wr(3'd3, 16'h1234);
    base = rise_cnt; flen = 32; n0 = rise_cnt;
    wr(3'd1, 16'd4);
    wr(3'd1, 16'd2);
    rd(3'd1, v); check("R6 command kept", v, 4);
    wait_idle();
    check("R6 single frame", rise_cnt - n0, 32);
    check("R6 write frame kept", cap[31:0], exp_frame(1'b0, 5'h01, 5'h02, 16'h1234));
    rd(3'd4, v); check("R6 rx untouched", v, 16'hFFFE);
    wr(3'd1, 16'd0);
    rd(3'd1, v); check("R6 zero accepted", v, 0);

    // R7 / R8 scan
    wr(3'd0, 16'h0102);
    wr(3'd2, 16'h1C07);
    base = rise_cnt; flen = 32; resp_on = 1; resp = 16'h0004;
    wr(3'd1, 16'd1);
    rd(3'd5, v); check("R7 scan start status", v[2:0], 3'b110);
    wait (rise_cnt == base + 32);
    #1 check("R7 scan header", cap[31:18], exp_frame(1'b1, 5'h07, 5'h01, 16'h0) >> 18);
    wait (rise_cnt == base + 33);
    rd(3'd5, v); check("R7 first result link up", v[2:0], 3'b010);
    rd(3'd4, v); check("R7 scan rx", v, 16'h0004);
    resp = 16'h0000;
    wait (rise_cnt == base + 65);
    rd(3'd5, v); check("R7 link fail", v[2:0], 3'b011);
    wr(3'd1, 16'd0);
    wait_idle();
    check("R8 scan stops after frame", rise_cnt - base, 96);
    repeat (20) @(negedge clk);
    check("R8 no further frame", rise_cnt - base, 96);
    rd(3'd5, v); check("R8 idle status", v[2:0], 3'b001);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule